// File: doc/BRIEF.md
# Streaming Pixel Ratio Pipeline

This block divides one live pixel stream by a second, aligned one. For every beat it multiplies the stream A pixel by a run-time scale, keeps the full-width product, and divides that product by the stream B pixel at the same position. A typical use is flat-field or background correction. Stream A is the captured frame and stream B is a bright background frame. The scale then sets the output brightness.

Each beat carries a kind code, so line ends and frame ends travel through the pipeline in step with the pixels. The pipeline accepts one beat per clock. It has a fixed depth, and a stall from downstream freezes every stage at once, so no beat is lost. Two modes are available:

- **Grayscale:** a single lane whose width is set by `PIX_W`.
- **Colour:** a 32-bit word with three 8-bit channels that are each divided independently, plus a fourth byte carried through unchanged.

Top module: `pixel_ratio_pipe`

## Requirements
- R1: For a pixel beat, each computed lane equals floor(A × K / B). Here K is the scale in force for the frame, and the product is formed at full width (lane width + `K_W` bits), so no bits are dropped before the divide.
- R2: When the B lane value is zero, that output lane is all ones (the largest lane value).
- R3: When the quotient exceeds the largest lane value, that output lane is all ones.
- R4: `in_kind` codes are 0 for a pixel, 1 for end of line and 2 for end of frame (3 is reserved). Each output beat carries the kind of the input beat it came from. On marker beats the output data is all zeros and the A and B data are ignored.
- R5: A beat accepted on clock edge n is handed downstream on edge n + LW + 2 when `out_ready` stays high, where LW is the lane width (8 in colour mode, `PIX_W` otherwise). With no stall, one beat is accepted every cycle.
- R6: `in_ready` is high whenever `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_kind` and `out_pix` hold. Every accepted beat comes out exactly once, in order.
- R7: The scale is sampled on the first accepted beat after reset and on the first accepted beat after an end-of-frame beat. The value of `scale` on any other beat has no effect.
- R8: In colour mode, output bytes [7:0], [15:8] and [23:16] are each computed from the matching bytes of A and of the 24-bit B bus. Output byte [31:24] is a copy of A byte [31:24].
- R9: While `rst_n` is low, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present on A, B and kind |
| in_ready | output | 1 | Block takes the input beat on this edge |
| in_kind | input | 2 | Beat kind shared by both streams: pixel, end of line, end of frame |
| a_pix | input | 32 (colour) / PIX_W | Stream A pixel (captured frame) |
| b_pix | input | 24 (colour) / PIX_W | Stream B pixel (background frame) |
| scale | input | K_W | Integer multiplier, latched per frame |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the output beat; tie high if never stalled |
| out_kind | output | 2 | Kind of the output beat |
| out_pix | output | 32 (colour) / PIX_W | Result pixel |

## Verification
The bench builds two instances side by side. The first is a 16-bit grayscale unit with an 8-bit scale: its 24-bit products overflow the lane in many cases, so saturation and the upper-bits overflow pre-check are reached, and its 18-cycle depth is measured. The second is a colour unit with 8-bit lanes and a depth of 10, where lanes with zero divisors, saturating lanes and normal lanes share one word and the fourth byte must come through untouched. Both instances see frame structures with line and frame markers, a scale that changes on every beat, and random stalls after an initial free-running stretch.

// File: rtl/pixel_ratio_pipe.sv
`timescale 1ns/1ps
module pixel_ratio_pipe #(
  parameter int PIX_W = 8,
  parameter int K_W   = 8,
  parameter bit COLOR = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [1:0]                    in_kind,
  input  logic [(COLOR ? 32 : PIX_W)-1:0] a_pix,
  input  logic [(COLOR ? 24 : PIX_W)-1:0] b_pix,
  input  logic [K_W-1:0]                scale,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [1:0]                    out_kind,
  output logic [(COLOR ? 32 : PIX_W)-1:0] out_pix
);
  localparam int LW = COLOR ? 8 : PIX_W;
  localparam int NC = COLOR ? 3 : 1;
  localparam int BW = COLOR ? 32 : PIX_W;
  localparam int PW = LW + K_W;
  localparam int ST = LW;
  localparam logic [1:0] KD_PIX = 2'd0;
  localparam logic [1:0] KD_EOI = 2'd2;

  logic adv, fire, fst;
  logic [K_W-1:0] k_hold, k_eff;
  logic [ST:0] v;
  logic [ST:0][1:0] kd;
  logic [BW-1:0] res;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign fire     = in_valid && adv;
  assign k_eff    = fst ? scale : k_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fst    <= 1'b1;
      k_hold <= '0;
    end else if (fire) begin
      fst <= (in_kind == KD_EOI);
      if (fst) k_hold <= scale;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v  <= '0;
      kd <= '0;
    end else if (adv) begin
      v  <= {v[ST-1:0], fire};
      kd <= {kd[ST-1:0], in_kind};
    end
  end

  for (genvar l = 0; l < NC; l++) begin : g_lane
    logic [PW-1:0] prod;
    logic [K_W-1:0] hi;
    logic [LW-1:0] bl;
    logic [ST:0][LW-1:0] rem, dq, dv, rem_d, dq_d, dv_d;
    logic [ST:0] sat, sat_d;

    assign bl   = b_pix[l*LW +: LW];
    assign prod = PW'(a_pix[l*LW +: LW]) * PW'(k_eff);
    assign hi   = prod[PW-1:LW];

    always_comb begin
      logic [LW:0] sh, df;
      sh = '0;
      df = '0;
      rem_d[0] = LW'(hi);
      dq_d[0]  = prod[LW-1:0];
      dv_d[0]  = bl;
      sat_d[0] = PW'(hi) >= PW'(bl);
      for (int s = 1; s <= ST; s++) begin
        sh = {rem[s-1], dq[s-1][LW-1]};
        df = sh - {1'b0, dv[s-1]};
        rem_d[s] = df[LW] ? sh[LW-1:0] : df[LW-1:0];
        dq_d[s]  = {dq[s-1][LW-2:0], ~df[LW]};
        dv_d[s]  = dv[s-1];
        sat_d[s] = sat[s-1];
      end
    end

    always_ff @(posedge clk) begin
      if (adv) begin
        rem <= rem_d;
        dq  <= dq_d;
        dv  <= dv_d;
        sat <= sat_d;
      end
    end

    assign res[l*LW +: LW] = sat[ST] ? {LW{1'b1}} : dq[ST];

    for (genvar s = 0; s <= ST; s++) begin : g_chk
      assert_rem_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (v[s] && !sat[s]) |-> (rem[s] < dv[s]));
    end
  end

  if (COLOR) begin : g_alpha
    logic [ST:0][7:0] alp;
    always_ff @(posedge clk) begin
      if (adv) alp <= {alp[ST-1:0], a_pix[31:24]};
    end
    assign res[31:24] = alp[ST];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_kind  <= '0;
      out_pix   <= '0;
    end else if (adv) begin
      out_valid <= v[ST];
      out_kind  <= kd[ST];
      out_pix   <= (kd[ST] == KD_PIX) ? res : '0;
    end
  end

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(out_kind)));

  assert_marker_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind != KD_PIX) |-> (out_pix == '0));

  assert_scale_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(k_hold) |-> $past(fire && fst));

  assert_stall_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/pixel_ratio_pipe_tb.sv
`timescale 1ns/1ps
module pixel_ratio_pipe_tb;
  localparam int GW = 16;
  localparam int KW = 8;
  localparam int LAT_G = GW + 2;
  localparam int LAT_C = 8 + 2;
  localparam int N_BEATS = 2500;
  localparam int FREE = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  longint cyc = 0;
  always @(posedge clk) cyc++;

  int checks = 0;
  int fails = 0;
  bit done_g = 1'b0;
  bit done_c = 1'b0;

  logic g_iv, g_ir, g_ov, g_or;
  logic [1:0] g_kind, g_ok;
  logic [GW-1:0] g_a, g_b, g_o;
  logic [KW-1:0] g_k;

  logic c_iv, c_ir, c_ov, c_or;
  logic [1:0] c_kind, c_ok;
  logic [31:0] c_a, c_o;
  logic [23:0] c_b;
  logic [KW-1:0] c_k;

  pixel_ratio_pipe #(.PIX_W(GW), .K_W(KW), .COLOR(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(g_iv), .in_ready(g_ir), .in_kind(g_kind),
    .a_pix(g_a), .b_pix(g_b), .scale(g_k), .out_valid(g_ov), .out_ready(g_or),
    .out_kind(g_ok), .out_pix(g_o));

  pixel_ratio_pipe #(.PIX_W(8), .K_W(KW), .COLOR(1'b1)) u_dut_rgb (
    .clk(clk), .rst_n(rst_n), .in_valid(c_iv), .in_ready(c_ir), .in_kind(c_kind),
    .a_pix(c_a), .b_pix(c_b), .scale(c_k), .out_valid(c_ov), .out_ready(c_or),
    .out_kind(c_ok), .out_pix(c_o));

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic longint lq(longint a, longint b, longint k, longint mx);
    longint q;
    if (b == 0) return mx;
    q = (a * k) / b;
    return (q > mx) ? mx : q;
  endfunction

  initial begin : drv_g
    int sent, px, ln, r;
    bit fst, stalled, took, hchk;
    logic [KW-1:0] kf, keff;
    logic [GW-1:0] hd;
    logic [1:0] hk;
    longint d, lat, raw, ed;
    string t;
    longint qd[$];
    logic [1:0] qk[$];
    longint qc[$];
    string qt[$];
    sent = 0; px = 0; ln = 0; fst = 1; stalled = 0; took = 0; hchk = 0;
    kf = '0; hd = '0; hk = '0;
    g_iv = 0; g_kind = 0; g_a = 0; g_b = 0; g_k = 0; g_or = 1;
    wait (rst_n);
    while (sent < N_BEATS || qd.size() > 0) begin
      @(negedge clk);
      if (!g_iv || took) begin
        if (sent < N_BEATS && (sent < FREE || $urandom_range(3) != 0)) begin
          g_iv = 1;
          if (px == 6) begin
            g_kind = (ln == 2) ? 2'd2 : 2'd1;
            px = 0;
            ln = (ln == 2) ? 0 : ln + 1;
          end else begin
            g_kind = 2'd0;
            px++;
          end
          r = $urandom_range(7);
          g_a = (r == 3) ? 16'hFFFF : 16'($urandom);
          g_b = (r == 0) ? 16'd0 : (r == 1) ? 16'd1 :
                (r == 2) ? 16'($urandom_range(16, 1)) : 16'($urandom);
          g_k = ($urandom_range(9) == 0) ? 8'd0 : 8'($urandom);
        end else begin
          g_iv = 0;
        end
      end
      g_or = (sent < FREE) ? 1'b1 : ($urandom_range(9) < 7);
      if (!g_or) stalled = 1;
      #1;
      if (hchk) check("R6 hold", {g_ov, g_o, g_ok}, {1'b1, hd, hk});
      hchk = g_ov && !g_or;
      hd = g_o;
      hk = g_ok;
      if (g_ov && g_or) begin
        if (qd.size() == 0) check("R6 spurious beat", 1, 0);
        else begin
          d = qd.pop_front();
          t = qt.pop_front();
          check(t, g_ok, qk.pop_front());
          check(t, g_o, d);
          lat = cyc - qc.pop_front();
          if (!stalled) check("R5 latency", lat, LAT_G);
          else check("R5 latency floor", lat >= LAT_G, 1);
        end
      end
      took = g_iv && g_ir;
      if (took) begin
        keff = fst ? g_k : kf;
        if (fst) kf = g_k;
        if (g_kind != 2'd0) begin
          ed = 0;
          t = "R4 marker";
        end else begin
          raw = (g_b == 0) ? 0 : (longint'(g_a) * keff) / g_b;
          ed = lq(g_a, g_b, keff, 65535);
          if (g_b == 0) t = "R2 zero divisor";
          else if (raw > 65535) t = "R3 saturate";
          else if (keff != g_k) t = "R7 frame scale";
          else t = "R1 ratio";
        end
        fst = (g_kind == 2'd2);
        qd.push_back(ed);
        qk.push_back(g_kind);
        qc.push_back(cyc);
        qt.push_back(t);
        sent++;
      end
    end
    done_g = 1;
  end

  initial begin : drv_c
    int sent, px, ln, r;
    bit fst, stalled, took, hchk;
    logic [KW-1:0] kf, keff;
    logic [31:0] hd;
    logic [1:0] hk;
    longint d, lat, ed;
    string t;
    longint qd[$];
    logic [1:0] qk[$];
    longint qc[$];
    string qt[$];
    sent = 0; px = 0; ln = 0; fst = 1; stalled = 0; took = 0; hchk = 0;
    kf = '0; hd = '0; hk = '0;
    c_iv = 0; c_kind = 0; c_a = 0; c_b = 0; c_k = 0; c_or = 1;
    wait (rst_n);
    while (sent < N_BEATS || qd.size() > 0) begin
      @(negedge clk);
      if (!c_iv || took) begin
        if (sent < N_BEATS && (sent < FREE || $urandom_range(3) != 0)) begin
          c_iv = 1;
          if (px == 5) begin
            c_kind = (ln == 3) ? 2'd2 : 2'd1;
            px = 0;
            ln = (ln == 3) ? 0 : ln + 1;
          end else begin
            c_kind = 2'd0;
            px++;
          end
          c_a = $urandom;
          for (int l = 0; l < 3; l++) begin
            r = $urandom_range(7);
            c_b[l*8 +: 8] = (r == 0) ? 8'd0 : (r == 1) ? 8'd1 :
                            (r == 2) ? 8'($urandom_range(8, 1)) : 8'($urandom);
          end
          c_k = ($urandom_range(9) == 0) ? 8'd0 : 8'($urandom);
        end else begin
          c_iv = 0;
        end
      end
      c_or = (sent < FREE) ? 1'b1 : ($urandom_range(9) < 6);
      if (!c_or) stalled = 1;
      #1;
      if (hchk) check("R6 hold", {c_ov, c_o, c_ok}, {1'b1, hd, hk});
      hchk = c_ov && !c_or;
      hd = c_o;
      hk = c_ok;
      if (c_ov && c_or) begin
        if (qd.size() == 0) check("R6 spurious beat", 1, 0);
        else begin
          d = qd.pop_front();
          t = qt.pop_front();
          check(t, c_ok, qk.pop_front());
          check(t, c_o, d);
          lat = cyc - qc.pop_front();
          if (!stalled) check("R5 latency", lat, LAT_C);
          else check("R5 latency floor", lat >= LAT_C, 1);
        end
      end
      took = c_iv && c_ir;
      if (took) begin
        keff = fst ? c_k : kf;
        if (fst) kf = c_k;
        if (c_kind != 2'd0) begin
          ed = 0;
          t = "R4 marker";
        end else begin
          ed = longint'(c_a[31:24]) << 24;
          for (int l = 0; l < 3; l++)
            ed = ed | (lq(c_a[l*8 +: 8], c_b[l*8 +: 8], keff, 255) << (8 * l));
          t = (keff != c_k) ? "R7 frame scale" : "R8 colour lanes";
        end
        fst = (c_kind == 2'd2);
        qd.push_back(ed);
        qk.push_back(c_kind);
        qc.push_back(cyc);
        qt.push_back(t);
        sent++;
      end
    end
    done_c = 1;
  end

  initial begin : main
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R9 reset out_valid gray", g_ov, 0);
    check("R9 reset in_ready gray", g_ir, 1);
    check("R9 reset out_valid colour", c_ov, 0);
    check("R9 reset in_ready colour", c_ir, 1);
    rst_n = 1'b1;
    while (!(done_g && done_c) && cyc < 150000) @(posedge clk);
    if (!(done_g && done_c)) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d (drivers unfinished)", cyc, 150000);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule